// File: doc/BRIEF.md
# Data-Processing Bus-Cycle Sequencer

This block is the control sequencer that a three-stage pipelined 32-bit core uses to run a data-processing instruction through its bus cycles. Decode raises an issue strobe along with two decoded flags. One flag says the shift distance is held in a register. The other says the result is written to the program counter. The sequencer then plays out the bus-cycle types for that instruction, one per clock: sequential (S), non-sequential (N) or internal (I).

It also drives several control outputs:
- a flush during the N cycle, so the fetch and decode stages drop their contents before the pipeline refills;
- a read enable for the second register-file port during the I cycle, so the shift distance can be fetched there;
- a stall back to decode;
- a one-clock done pulse on the final S cycle.

The barrel shifter covers any distance in one pass, so the shift distance never changes the cycle count. Only the source of the shift distance and the destination register matter.

Top module: `dp_cycle_seq`

## Requirements
- R1: While `rst_n` is low, `cyc_type` is 2'b11 (idle) and `flush`, `shamt_rd_en`, `stall` and `done` are all 0.
- R2: An accepted issue with both flags low produces, starting the clock after the accepting edge, a single cycle of type S (2'b00).
- R3: An accepted issue with only `shift_by_reg` high produces I (2'b10) then S. `shamt_rd_en` is 1 exactly during the I cycle.
- R4: An accepted issue with only `dest_pc` high produces N (2'b01), then S, then S. `flush` is 1 exactly during the N cycle.
- R5: An accepted issue with both flags high produces I, then N, then S, then S.
- R6: `stall` is 1 in every cycle of a sequence except its last cycle, and 0 otherwise.
- R7: `done` is 1 for exactly one clock, on the final S cycle of each sequence.
- R8: An `issue` that arrives while `stall` is 1 is ignored. The running sequence continues unchanged and no extra sequence follows.
- R9: An `issue` sampled in the final cycle of a sequence is accepted, and its first cycle follows with no idle gap.
- R10: `shift_by_reg` and `dest_pc` are sampled only at the accepting edge. Changes to them during a sequence do not alter it.
- R11: With no sequence running, `cyc_type` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| issue | input | 1 | Decode offers a data-processing instruction |
| shift_by_reg | input | 1 | Shift distance comes from a register |
| dest_pc | input | 1 | Destination is the program counter |
| cyc_type | output | 2 | Bus-cycle type: 00 S, 01 N, 10 I, 11 idle |
| flush | output | 1 | Discard fetch and decode contents (N cycle) |
| shamt_rd_en | output | 1 | Read the shift-distance register (I cycle) |
| stall | output | 1 | Hold decode; low on the last cycle and when idle |
| done | output | 1 | One-clock pulse on the final S cycle |

## Verification
The bench builds the block with the default refill depth of two, which gives the full four-cycle I-N-S-S sequence as the longest case. It makes every step index reachable, including the wrap from the last index straight into a new sequence. Random issue rates near one half produce many issues that land on stalled cycles and on final cycles, so the paths where an issue is ignored and where back-to-back issues are accepted are both covered. Directed runs change the flags in the middle of a sequence to show that they are only latched at the accepting edge.

// File: rtl/dpcs_pkg.sv
package dpcs_pkg;
  typedef enum logic [1:0] {
    CT_S    = 2'b00,
    CT_N    = 2'b01,
    CT_I    = 2'b10,
    CT_IDLE = 2'b11
  } cyc_t;
endpackage

// File: rtl/dpcs_len.sv
// Derives the index of the final step from the decoded flags.
module dpcs_len #(
  parameter int REFILL = 2,
  parameter int STEP_W = 2
) (
  input  logic              sreg,
  input  logic              pc,
  output logic [STEP_W-1:0] last_idx
);
  always_comb begin
    last_idx = STEP_W'(sreg);
    if (pc) last_idx = last_idx + STEP_W'(REFILL);
  end
endmodule

// File: rtl/dpcs_ctrl.sv
// State registers: busy flag, step index, latched flags and final index.
module dpcs_ctrl #(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              sreg_in,
  input  logic              pc_in,
  input  logic [STEP_W-1:0] last_in,
  output logic              busy_q,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] last_q,
  output logic              sreg_q,
  output logic              pc_q,
  output logic              final_o
);
  logic              accept;
  logic              en;
  logic              busy_d;
  logic [STEP_W-1:0] step_d;
  logic [STEP_W-1:0] last_d;
  logic              sreg_d;
  logic              pc_d;

  assign final_o = busy_q && (step_q == last_q);
  assign accept  = issue && (!busy_q || final_o);
  assign en      = accept || busy_q;

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    last_d = last_q;
    sreg_d = sreg_q;
    pc_d   = pc_q;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
      last_d = last_in;
      sreg_d = sreg_in;
      pc_d   = pc_in;
    end else if (final_o) begin
      busy_d = 1'b0;
      step_d = '0;
    end else if (busy_q) begin
      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      last_q <= '0;
      sreg_q <= 1'b0;
      pc_q   <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      step_q <= step_d;
      last_q <= last_d;
      sreg_q <= sreg_d;
      pc_q   <= pc_d;
    end
  end

  assert_accept_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && step_q == '0));
  assert_ignored_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !final_o) |=> (busy_q && step_q == $past(step_q) + 1'b1));
  assert_flags_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !final_o) |=> $stable({sreg_q, pc_q, last_q}));
endmodule

// File: rtl/dpcs_decode.sv
// Maps the current step to the bus-cycle type and the control strobes.
module dpcs_decode
  import dpcs_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  logic [STEP_W-1:0] last,
  input  logic              sreg,
  input  logic              pc,
  output logic [1:0]        cyc_type,
  output logic              flush,
  output logic              shamt_rd_en,
  output logic              stall,
  output logic              done
);
  cyc_t ct;

  always_comb begin
    if (!busy)                              ct = CT_IDLE;
    else if (sreg && step == '0)            ct = CT_I;
    else if (pc && step == STEP_W'(sreg))   ct = CT_N;
    else                                    ct = CT_S;
  end

  assign cyc_type    = ct;
  assign flush       = (ct == CT_N);
  assign shamt_rd_en = (ct == CT_I);
  assign done        = busy && (step == last);
  assign stall       = busy && (step != last);
endmodule

// File: rtl/dp_cycle_seq.sv
module dp_cycle_seq
  import dpcs_pkg::*;
#(
  parameter int REFILL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic       shift_by_reg,
  input  logic       dest_pc,
  output logic [1:0] cyc_type,
  output logic       flush,
  output logic       shamt_rd_en,
  output logic       stall,
  output logic       done
);
  localparam int MAX_LEN = REFILL + 2;
  localparam int STEP_W  = $clog2(MAX_LEN);

  logic [STEP_W-1:0] last_in;
  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_q;
  logic              sreg_q;
  logic              pc_q;
  logic              final_w;

  dpcs_len #(.REFILL(REFILL), .STEP_W(STEP_W)) u_len (
    .sreg     (shift_by_reg),
    .pc       (dest_pc),
    .last_idx (last_in)
  );

  dpcs_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .sreg_in (shift_by_reg),
    .pc_in   (dest_pc),
    .last_in (last_in),
    .busy_q  (busy_q),
    .step_q  (step_q),
    .last_q  (last_q),
    .sreg_q  (sreg_q),
    .pc_q    (pc_q),
    .final_o (final_w)
  );

  dpcs_decode #(.STEP_W(STEP_W)) u_dec (
    .busy        (busy_q),
    .step        (step_q),
    .last        (last_q),
    .sreg        (sreg_q),
    .pc          (pc_q),
    .cyc_type    (cyc_type),
    .flush       (flush),
    .shamt_rd_en (shamt_rd_en),
    .stall       (stall),
    .done        (done)
  );

  initial begin
    assert (REFILL >= 1) else $error("REFILL must be at least 1");
  end

  assert_flush_then_s_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cyc_type == CT_S && !flush));
  assert_rd_then_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shamt_rd_en |=> (cyc_type == CT_N || cyc_type == CT_S));
  assert_done_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall);
  assert_stall_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (cyc_type != CT_IDLE));
  assert_done_on_s_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_type == CT_S));
  assert_strobes_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush, shamt_rd_en, done}));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == CT_IDLE) |-> !(stall || done || flush || shamt_rd_en));
endmodule

// File: tb/test_dp_cycle_seq.sv
module test_dp_cycle_seq;
  localparam int CLK_PERIOD = 10;
  localparam int REFILL     = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       issue, shift_by_reg, dest_pc;
  logic [1:0] cyc_type;
  logic       flush, shamt_rd_en, stall, done;

  int    nvec  = 0;
  int    nfail = 0;
  string phase = "init";

  int    m_seq [0:REFILL+1];
  int    m_len = 0;
  int    m_pos = 0;
  bit    m_busy = 0;
  string m_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_cycle_seq #(.REFILL(REFILL)) i_dp_cycle_seq (
    .clk(clk), .rst_n(rst_n), .issue(issue), .shift_by_reg(shift_by_reg),
    .dest_pc(dest_pc), .cyc_type(cyc_type), .flush(flush),
    .shamt_rd_en(shamt_rd_en), .stall(stall), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s phase=%s t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  function automatic string tag_of(input bit s, input bit p);
    if (s && p) return "R5";
    if (p)      return "R4";
    if (s)      return "R3";
    return "R2";
  endfunction

  task automatic load_seq(input bit s, input bit p);
    m_len = 0;
    if (s) begin m_seq[m_len] = 2; m_len++; end
    if (p) begin
      m_seq[m_len] = 1; m_len++;
      for (int k = 1; k < REFILL; k++) begin m_seq[m_len] = 0; m_len++; end
    end
    m_seq[m_len] = 0; m_len++;
    m_tag = tag_of(s, p);
  endtask

  task automatic cyc(input bit iss, input bit s, input bit p);
    bit acc;
    int e_ct;
    bit e_done;
    @(negedge clk);
    issue = iss; shift_by_reg = s; dest_pc = p;
    acc = iss && !(m_busy && m_pos != m_len - 1);
    @(posedge clk);
    if (acc) begin
      load_seq(s, p); m_pos = 0; m_busy = 1;
    end else if (m_busy) begin
      if (m_pos == m_len - 1) m_busy = 0;
      else m_pos++;
    end
    #2;
    e_ct   = m_busy ? m_seq[m_pos] : 3;
    e_done = m_busy && (m_pos == m_len - 1);
    chk(m_busy ? m_tag : "R11", int'(cyc_type), e_ct);
    chk("R6", int'(stall), int'(m_busy && !e_done));
    chk("R7", int'(done), int'(e_done));
    chk("R4", int'(flush), int'(e_ct == 1));
    chk("R3", int'(shamt_rd_en), int'(e_ct == 2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; issue = 1'b0; shift_by_reg = 1'b0; dest_pc = 1'b0;
    #(CLK_PERIOD*2 + 2);
    phase = "reset";
    chk("R1", int'(cyc_type), 3);
    chk("R1", int'(flush), 0);
    chk("R1", int'(shamt_rd_en), 0);
    chk("R1", int'(stall), 0);
    chk("R1", int'(done), 0);
    @(negedge clk); rst_n = 1'b1;

    phase = "R2 plain";   cyc(1,0,0); cyc(0,0,0); cyc(0,0,0);
    phase = "R3 regsh";   cyc(1,1,0); cyc(0,0,0); cyc(0,0,0);
    phase = "R4 pcdst";   cyc(1,0,1); cyc(0,0,0); cyc(0,0,0); cyc(0,0,0);
    phase = "R5 both";    cyc(1,1,1); for (int i = 0; i < 4; i++) cyc(0,0,0);
    phase = "R8 R10 ign"; cyc(1,1,1); cyc(1,0,0); cyc(1,0,0); cyc(1,0,1);
    phase = "R9 b2b";     cyc(1,1,0); cyc(1,0,0); cyc(1,0,0); cyc(0,1,1); cyc(0,0,0);
    phase = "R10 flip";   cyc(1,0,1); cyc(0,1,0); cyc(0,1,1); cyc(0,0,0);

    phase = "random";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 100) < 55, $urandom % 2, $urandom % 2);
    for (int i = 0; i < 5; i++) cyc(0,0,0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule